// File: doc/BRIEF.md
# Varicode Character Bit Serializer

The serializer takes 8-bit characters over a valid/ready handshake and turns each one into a variable-length code word, which it sends one bit at a time to a downstream symbol modulator. The modulator pulls bits with a one-cycle request strobe, once per symbol period. The block answers each request with one bit and a one-cycle valid flag.

Frequent characters get short code words. No code word holds two zero bits in a row, so a pair of zeros marks where a character ends. After the last code bit of each character, the block sends exactly two zero bits. When no character is waiting, every request is answered with a zero, which gives the idle pattern. The code table is combinational logic inside the block. It covers the space character and the lowercase letters.

Top module: `vcode_ser`

## Requirements
- R1: While reset is asserted and just after it is released, `char_ready_o` is 1 and `bit_valid_o` is 0.
- R2: `bit_valid_o` is 1 in exactly the cycle after each cycle in which `bit_req_i` is 1, and 0 in every other cycle.
- R3: When no character is held, every request returns `bit_o` = 0.
- R4: A character is taken on a clock edge where `char_valid_i` and `char_ready_o` are both 1. `char_ready_o` is 0 in the following cycle.
- R5: Code bits are sent MSB first. The first and the last code bit of every character are 1.
- R6: Exactly two 0 bits follow the last code bit. `char_ready_o` returns to 1 in the cycle in which the second separator zero is presented, and not earlier.
- R7: No code word contains two adjacent 0 bits, and every code word is 1 to 10 bits long.
- R8: The space byte 0x20 sends "1", 'e' (0x65) sends "11", 't' (0x74) sends "101", and 'o' (0x6F) sends "111".
- R9: The 26 lowercase bytes 0x61 to 0x7A each have a distinct code word. Every byte other than these and 0x20 sends the same code as space.
- R10: A character offered while `char_ready_o` is 0 is not taken. It is taken after the current character's separator, and its bits follow that separator with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_i | input | 8 | Character byte |
| char_valid_i | input | 1 | Character byte is valid |
| char_ready_o | output | 1 | Block can take a character |
| bit_req_i | input | 1 | One-cycle request for the next symbol bit |
| bit_o | output | 1 | Serialized bit, meaningful when bit_valid_o is 1 |
| bit_valid_o | output | 1 | One-cycle flag: bit_o carries the requested bit |

## Verification
The bench uses the default build: 10-bit code words, a 4-bit length field and a two-bit separator. At this size every one of the 256 byte values can be sent through the serializer and its full bit stream collected. That sweep exposes the shape of each code word, the exact separator length, the ready timing, whether the lowercase codes are distinct, and the fallback to space for every unsupported byte. Separate runs cover the idle zeros and a character that is held waiting while another is being sent.

// File: rtl/vcode_pkg.sv
package vcode_pkg;
  localparam int CODE_W   = 10;
  localparam int LEN_W    = 4;
  localparam int SEP_BITS = 2;
  localparam int SEP_W    = $clog2(SEP_BITS + 1);

  typedef struct packed {
    logic [CODE_W-1:0] bits;  // left-aligned
    logic [LEN_W-1:0]  len;
  } vcode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CODE, ST_SEP} ser_st_e;

  // right-aligned pattern of l bits -> left-aligned entry
  function automatic vcode_t mk(input logic [CODE_W-1:0] b, input int l);
    vcode_t e;
    e.bits = b << (CODE_W - l);
    e.len  = LEN_W'(l);
    return e;
  endfunction
endpackage

// File: rtl/vcode_lut.sv
module vcode_lut
  import vcode_pkg::*;
(
  input  logic [7:0] char_i,
  output vcode_t     code_o
);
  always_comb begin
    unique case (char_i)
      8'h61: code_o = mk(10'b1011, 4);
      8'h62: code_o = mk(10'b1011111, 7);
      8'h63: code_o = mk(10'b101111, 6);
      8'h64: code_o = mk(10'b101101, 6);
      8'h65: code_o = mk(10'b11, 2);
      8'h66: code_o = mk(10'b111101, 6);
      8'h67: code_o = mk(10'b1011011, 7);
      8'h68: code_o = mk(10'b101011, 6);
      8'h69: code_o = mk(10'b1101, 4);
      8'h6a: code_o = mk(10'b111101011, 9);
      8'h6b: code_o = mk(10'b10111111, 8);
      8'h6c: code_o = mk(10'b11011, 5);
      8'h6d: code_o = mk(10'b111011, 6);
      8'h6e: code_o = mk(10'b1111, 4);
      8'h6f: code_o = mk(10'b111, 3);
      8'h70: code_o = mk(10'b111111, 6);
      8'h71: code_o = mk(10'b110111111, 9);
      8'h72: code_o = mk(10'b10101, 5);
      8'h73: code_o = mk(10'b10111, 5);
      8'h74: code_o = mk(10'b101, 3);
      8'h75: code_o = mk(10'b110111, 6);
      8'h76: code_o = mk(10'b1111011, 7);
      8'h77: code_o = mk(10'b1101011, 7);
      8'h78: code_o = mk(10'b11011111, 8);
      8'h79: code_o = mk(10'b1011101, 7);
      8'h7a: code_o = mk(10'b111010101, 9);
      default: code_o = mk(10'b1, 1);  // space and all unsupported bytes
    endcase
  end

  // p_code_shape_r7: length in range, leading and trailing bit set
  always_comb begin
    if (!$isunknown(char_i)) begin
      p_code_shape_r7: assert (code_o.len >= 1 && int'(code_o.len) <= CODE_W
                               && code_o.bits[CODE_W-1]
                               && code_o.bits[CODE_W - int'(code_o.len)]);
    end
  end
endmodule

// File: rtl/vcode_fsm.sv
module vcode_fsm
  import vcode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  vcode_t     code_i,
  input  logic       char_valid_i,
  output logic       char_ready_o,
  input  logic       bit_req_i,
  output logic       bit_o,
  output logic       bit_valid_o
);
  ser_st_e           st_q;
  logic [CODE_W-1:0] sh_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [SEP_W-1:0]  sep_q;
  logic              bit_q, vld_q;
  logic              take;

  assign char_ready_o = (st_q == ST_IDLE);
  assign take         = char_valid_i && char_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      sep_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= bit_req_i;
      if (bit_req_i) bit_q <= (st_q == ST_CODE) ? sh_q[CODE_W-1] : 1'b0;
      unique case (st_q)
        ST_IDLE: if (take) begin
          sh_q  <= code_i.bits;
          cnt_q <= code_i.len;
          st_q  <= ST_CODE;
        end
        ST_CODE: if (bit_req_i) begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) begin
            st_q  <= ST_SEP;
            sep_q <= SEP_W'(SEP_BITS);
          end
        end
        ST_SEP: if (bit_req_i) begin
          sep_q <= sep_q - 1'b1;
          if (sep_q == SEP_W'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = vld_q;

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_req_i |=> bit_valid_o);
  p_valid_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_req_i |=> !bit_valid_o);
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && bit_req_i) |=> !bit_o);
  p_ready_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !char_ready_o);
  p_first_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CODE && bit_req_i && $past(st_q) == ST_IDLE) |=> bit_o);
  p_sep_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEP && bit_req_i && sep_q == SEP_W'(1)) |=> (char_ready_o && !bit_o));
  p_no_double_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_o && st_q == ST_CODE) |-> sh_q[CODE_W-1]);
endmodule

// File: rtl/vcode_ser.sv
module vcode_ser
  import vcode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] char_i,
  input  logic       char_valid_i,
  output logic       char_ready_o,
  input  logic       bit_req_i,
  output logic       bit_o,
  output logic       bit_valid_o
);
  vcode_t code;

  vcode_lut u_lut (
    .char_i (char_i),
    .code_o (code)
  );

  vcode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .code_i       (code),
    .char_valid_i (char_valid_i),
    .char_ready_o (char_ready_o),
    .bit_req_i    (bit_req_i),
    .bit_o        (bit_o),
    .bit_valid_o  (bit_valid_o)
  );

  p_reset_ready_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (char_ready_o && !bit_valid_o));
endmodule

// File: tb/sim_vcode_ser.sv
module sim_vcode_ser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ch = 8'h00;
  logic       ch_vld = 1'b0;
  logic       rdy;
  logic       req = 1'b0;
  logic       b;
  logic       bv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] lc_val [26];
  int          lc_len [26];
  logic [15:0] sp_val;
  int          sp_len;

  always #2 clk = ~clk;

  vcode_ser u0 (
    .clk_i(clk), .rst_ni(rst_n), .char_i(ch), .char_valid_i(ch_vld),
    .char_ready_o(rdy), .bit_req_i(req), .bit_o(b), .bit_valid_o(bv)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one request; returns bit and ready observed after it
  task automatic pull(output logic bit_v, output logic rdy_v);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    chk(bv === 1'b1, "R2 valid after req", int'(bv), 1);
    bit_v = b;
    rdy_v = rdy;
    @(negedge clk);
    chk(bv === 1'b0, "R2 valid quiet", int'(bv), 0);
  endtask

  // send one byte, collect stream up to ready, return code part
  task automatic xmit(input logic [7:0] c, output logic [15:0] val, output int len);
    logic [15:0] s;
    int n;
    logic bt, rv;
    @(negedge clk);
    chk(rdy === 1'b1, "R4 ready before take", int'(rdy), 1);
    ch = c; ch_vld = 1'b1;
    @(negedge clk) ch_vld = 1'b0;
    chk(rdy === 1'b0, "R4 ready low after take", int'(rdy), 0);
    s = '0; n = 0; rv = 1'b0;
    while (!rv && n < 16) begin
      pull(bt, rv);
      s = {s[14:0], bt};
      n++;
    end
    chk(rv === 1'b1, "R6 ready returns", int'(rv), 1);
    chk(s[1:0] == 2'b00, "R6 two zeros end", int'(s[1:0]), 0);
    chk(s[2] == 1'b1, "R5 last code bit one", int'(s[2]), 1);
    chk(n >= 3 && n <= 12, "R7 length", n - 2, 10);
    chk(s[n-1] == 1'b1, "R5 first code bit one", int'(s[n-1]), 1);
    for (int i = 2; i < n - 1; i++)
      chk(!(s[i] == 1'b0 && s[i+1] == 1'b0), "R7 no double zero", i, 0);
    val = s >> 2;
    len = n - 2;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int l;
    logic bt, rv;
    logic [15:0] s;
    repeat (3) @(negedge clk);
    chk(rdy === 1'b1, "R1 ready in reset", int'(rdy), 1);
    chk(bv === 1'b0, "R1 valid in reset", int'(bv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy === 1'b1, "R1 ready after reset", int'(rdy), 1);
    chk(bv === 1'b0, "R1 valid after reset", int'(bv), 0);

    // R3 idle zeros
    for (int k = 0; k < 6; k++) begin
      pull(bt, rv);
      chk(bt === 1'b0, "R3 idle zero", int'(bt), 0);
      chk(rv === 1'b1, "R3 idle ready", int'(rv), 1);
    end

    // R8 fixed codes
    xmit(8'h20, sp_val, sp_len);
    chk(sp_len == 1 && sp_val == 16'b1, "R8 space", int'(sp_val), 1);
    xmit(8'h65, v, l);
    chk(l == 2 && v == 16'b11, "R8 e", int'(v), 3);
    xmit(8'h74, v, l);
    chk(l == 3 && v == 16'b101, "R8 t", int'(v), 5);
    xmit(8'h6f, v, l);
    chk(l == 3 && v == 16'b111, "R8 o", int'(v), 7);

    // R9 sweep over all bytes
    for (int c = 0; c < 256; c++) begin
      xmit(8'(c), v, l);
      if (c >= 8'h61 && c <= 8'h7a) begin
        lc_val[c - 8'h61] = v;
        lc_len[c - 8'h61] = l;
      end else begin
        chk(l == sp_len && v == sp_val, "R9 fallback to space", int'(v), int'(sp_val));
      end
    end
    for (int i = 0; i < 26; i++)
      for (int j = i + 1; j < 26; j++)
        chk(!(lc_val[i] == lc_val[j] && lc_len[i] == lc_len[j]), "R9 distinct", i, j);

    // R10 byte held while busy: 'e' then 't' -> 11 00 101 00
    @(negedge clk);
    ch = 8'h65; ch_vld = 1'b1;
    @(negedge clk);
    ch = 8'h74;
    chk(rdy === 1'b0, "R10 busy not ready", int'(rdy), 0);
    s = '0;
    for (int k = 0; k < 9; k++) begin
      pull(bt, rv);
      s = {s[14:0], bt};
      if (k == 3) begin
        chk(rv === 1'b1, "R10 ready after separator", int'(rv), 1);
        ch_vld = 1'b0;  // taken at the edge before this negedge
        @(negedge clk);
        chk(rdy === 1'b0, "R10 second byte taken", int'(rdy), 0);
      end else if (k < 3) begin
        chk(rv === 1'b0, "R10 held byte not taken", int'(rv), 0);
      end
    end
    chk(s[8:0] == 9'b110010100, "R10 back-to-back stream", int'(s[8:0]), 9'b110010100);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule